// File: doc/BRIEF.md
# Stochastic Bitstream Arithmetic Unit

This block does arithmetic on fractions in [0,1] that travel as serial bitstreams, where the value of a stream is the fraction of its bits that are 1. Two binary operands are each turned into a stream by comparing them with the output of a dedicated pseudo-random shift register. A bitwise AND of the two streams carries their product. A bitwise OR carries the biased sum A+B−AB, which saturates towards 1 and acts as a built-in nonlinearity.

Every step is paced by a bit strobe, so the source streams, the result streams and the converters all advance together. Two window counters turn the product and sum streams back into binary counts over a window of 2^K bits. The running counts are visible throughout, so an early estimate can be read before the window closes. A start pulse reseeds both generators and clears the counters, which makes every run repeatable.

Top module: `sc_arith_unit`

## Requirements
- R1: After reset, stream_valid, count_valid, bits_seen, both partial counts and both latched counts are 0. Both generators hold their seeds, and the window exponent is 0, which gives single-bit windows until the first start.
- R2: Each generator is a W-bit shift register. On each accepted strobe it shifts left and puts the parity of (state AND mask) into bit 0. Operand A uses seed 0x01 and mask 0xB8, and operand B uses seed 0x5A and mask 0xB4 (defaults for W=8). The state never becomes zero.
- R3: On an accepted strobe, an operand's stream bit is 1 exactly when the operand, read as unsigned, is greater than its generator's current state. The state is taken before it advances.
- R4: The product bit is the AND of the two stream bits and the sum bit is their OR. A product bit is therefore never 1 while the sum bit is 0, and the product count never exceeds the sum count.
- R5: A strobe is accepted when bit_valid is high and start is low. The cycle after an accepted strobe, stream_valid is high for one cycle and bit_a, bit_b, bit_prod and bit_sum show that strobe's bits.
- R6: The window length is 2^min(win_log2, KMAX) bits and is captured at start. On the last accepted bit of a window, the ones of product and sum, including that bit, are latched into prod_count and sum_count, and count_valid is high for the next cycle. The next window starts at once, without reseeding.
- R7: The cycle after each accepted strobe, bits_seen, prod_partial and sum_partial show the bits and the ones counted so far in the current window. All three return to 0 when a window closes.
- R8: A start pulse reseeds both generators, clears bits_seen and both partials, and loads the window exponent. The latched counts keep their values. A strobe in the same cycle as start is discarded: it sets no stream_valid and does not advance a generator.
- R9: In a cycle with no accepted strobe, the generator states, bits_seen and both partials hold their values, and stream_valid and count_valid are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Reseed generators, clear window, load exponent |
| bit_valid | input | 1 | Bit strobe; advances all streams by one bit |
| val_a | input | W | Operand A, fraction val_a/2^W |
| val_b | input | W | Operand B, fraction val_b/2^W |
| win_log2 | input | KW | Window exponent K, captured at start |
| stream_valid | output | 1 | Stream bits below are fresh |
| bit_a | output | 1 | Stream bit of operand A |
| bit_b | output | 1 | Stream bit of operand B |
| bit_prod | output | 1 | Product stream bit (AND) |
| bit_sum | output | 1 | Biased sum stream bit (OR) |
| bits_seen | output | KMAX | Bits accepted in the current window |
| prod_partial | output | KMAX | Product ones so far in the current window |
| sum_partial | output | KMAX | Sum ones so far in the current window |
| prod_count | output | KMAX+1 | Product ones latched at the last window end |
| sum_count | output | KMAX+1 | Sum ones latched at the last window end |
| count_valid | output | 1 | One-cycle pulse after a window closes |

## Verification
The assertions take three things for granted. Reset releases with the generators on nonzero seeds whose masks include the top bit, so a state cannot collapse to zero. The operands are plain unsigned values. Start is a level that is sampled once per cycle. The stimulus respects these conditions: it applies start only at negative edges, holds the operands steady across each strobe edge, and includes a start that coincides with a strobe so that the rule that start wins is exercised. Window exponents go from 0 through values above KMAX, so the running counts stay inside the bounds the assertions claim.

// File: rtl/sc_arith_pkg.sv
package sc_arith_pkg;

    // One step of the four arithmetic streams
    typedef struct packed {
        logic a;
        logic b;
        logic prod;
        logic sum;
    } sc_bits_t;

    // Number of converters: product and sum
    localparam int unsigned SC_NUM_CONV = 2;
    localparam int unsigned SC_CONV_PROD = 0;
    localparam int unsigned SC_CONV_SUM  = 1;

endpackage

// File: rtl/sc_lfsr.sv
module sc_lfsr #(
    parameter int unsigned W    = 8,
    parameter logic [W-1:0] SEED = 8'h01,
    parameter logic [W-1:0] MASK = 8'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reseed,
    input  logic         advance,
    output logic [W-1:0] state_o
);

    logic [W-1:0] st_d, st_q;
    logic         fb;

    always_comb begin
        fb   = ^(st_q & MASK);
        st_d = st_q;
        if (reseed) begin
            st_d = SEED;
        end else if (advance) begin
            st_d = {st_q[W-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEED;
        else        st_q <= st_d;
    end

    assign state_o = st_q;

    p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0)
        else $error("generator state collapsed to zero");

    p_lfsr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!reseed && !advance) |=> $stable(st_q))
        else $error("generator moved without a strobe");

    p_lfsr_reseed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reseed |=> (st_q == SEED))
        else $error("generator not reseeded by start");

endmodule

// File: rtl/sc_stream_gen.sv
module sc_stream_gen #(
    parameter int unsigned W    = 8,
    parameter logic [W-1:0] SEED = 8'h01,
    parameter logic [W-1:0] MASK = 8'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reseed,
    input  logic         advance,
    input  logic [W-1:0] value,
    output logic         bit_o
);

    logic [W-1:0] rnd;

    sc_lfsr #(
        .W    (W),
        .SEED (SEED),
        .MASK (MASK)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (reseed),
        .advance (advance),
        .state_o (rnd)
    );

    always_comb begin
        bit_o = (value > rnd);
    end

    p_zero_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (value == '0) |-> !bit_o)
        else $error("zero operand produced a one");

endmodule

// File: rtl/sc_window_counter.sv
module sc_window_counter #(
    parameter int unsigned KMAX = 10,
    parameter int unsigned KW   = $clog2(KMAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [KW-1:0]   k_in,
    input  logic            strobe,
    input  logic            bit_in,
    output logic [KMAX-1:0] ones_o,
    output logic [KMAX-1:0] pos_o,
    output logic [KMAX:0]   count_o,
    output logic            count_valid_o
);

    typedef struct packed {
        logic [KW-1:0]   k;
        logic [KMAX-1:0] pos;
        logic [KMAX-1:0] ones;
        logic [KMAX:0]   count;
        logic            cvld;
    } win_state_t;

    win_state_t d, q;

    logic [KW-1:0]   k_clamped;
    logic [KMAX:0]   win_len;
    logic [KMAX-1:0] win_last;

    always_comb begin
        k_clamped = (k_in > KW'(KMAX)) ? KW'(KMAX) : k_in;
        win_len   = {{KMAX{1'b0}}, 1'b1} << q.k;
        win_last  = KMAX'(win_len - 1'b1);

        d      = q;
        d.cvld = 1'b0;
        if (start) begin
            d.k    = k_clamped;
            d.pos  = '0;
            d.ones = '0;
        end else if (strobe) begin
            if (q.pos == win_last) begin
                d.count = {1'b0, q.ones} + (KMAX + 1)'(bit_in);
                d.cvld  = 1'b1;
                d.pos   = '0;
                d.ones  = '0;
            end else begin
                d.pos  = q.pos + 1'b1;
                d.ones = q.ones + KMAX'(bit_in);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ones_o        = q.ones;
    assign pos_o         = q.pos;
    assign count_o       = q.count;
    assign count_valid_o = q.cvld;

    p_pos_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.pos <= win_last)
        else $error("window position beyond window length");

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.cvld |-> (q.count <= win_len))
        else $error("latched count exceeds window length");

    p_partial_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.ones <= q.pos)
        else $error("running ones exceed bits seen");

    p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.pos == '0 && q.ones == '0 && !q.cvld))
        else $error("start did not clear the window");

endmodule

// File: rtl/sc_arith_unit.sv
module sc_arith_unit
    import sc_arith_pkg::*;
#(
    parameter int unsigned  W      = 8,
    parameter int unsigned  KMAX   = 10,
    parameter int unsigned  KW     = $clog2(KMAX + 1),
    parameter logic [W-1:0] SEED_A = 8'h01,
    parameter logic [W-1:0] SEED_B = 8'h5A,
    parameter logic [W-1:0] MASK_A = 8'hB8,
    parameter logic [W-1:0] MASK_B = 8'hB4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            bit_valid,
    input  logic [W-1:0]    val_a,
    input  logic [W-1:0]    val_b,
    input  logic [KW-1:0]   win_log2,
    output logic            stream_valid,
    output logic            bit_a,
    output logic            bit_b,
    output logic            bit_prod,
    output logic            bit_sum,
    output logic [KMAX-1:0] bits_seen,
    output logic [KMAX-1:0] prod_partial,
    output logic [KMAX-1:0] sum_partial,
    output logic [KMAX:0]   prod_count,
    output logic [KMAX:0]   sum_count,
    output logic            count_valid
);

    typedef struct packed {
        sc_bits_t bits;
        logic     vld;
    } out_state_t;

    out_state_t out_d, out_q;

    logic     accept;
    sc_bits_t now;

    logic [SC_NUM_CONV-1:0]           conv_bit;
    logic [SC_NUM_CONV-1:0][KMAX-1:0] conv_ones;
    logic [SC_NUM_CONV-1:0][KMAX-1:0] conv_pos;
    logic [SC_NUM_CONV-1:0][KMAX:0]   conv_count;
    logic [SC_NUM_CONV-1:0]           conv_cvld;

    assign accept = bit_valid & ~start;

    sc_stream_gen #(
        .W    (W),
        .SEED (SEED_A),
        .MASK (MASK_A)
    ) u_gen_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (start),
        .advance (accept),
        .value   (val_a),
        .bit_o   (now.a)
    );

    sc_stream_gen #(
        .W    (W),
        .SEED (SEED_B),
        .MASK (MASK_B)
    ) u_gen_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (start),
        .advance (accept),
        .value   (val_b),
        .bit_o   (now.b)
    );

    always_comb begin
        now.prod = now.a & now.b;
        now.sum  = now.a | now.b;
        conv_bit[SC_CONV_PROD] = now.prod;
        conv_bit[SC_CONV_SUM]  = now.sum;
    end

    for (genvar g = 0; g < SC_NUM_CONV; g++) begin : g_conv
        sc_window_counter #(
            .KMAX (KMAX),
            .KW   (KW)
        ) u_cnt (
            .clk           (clk),
            .rst_n         (rst_n),
            .start         (start),
            .k_in          (win_log2),
            .strobe        (accept),
            .bit_in        (conv_bit[g]),
            .ones_o        (conv_ones[g]),
            .pos_o         (conv_pos[g]),
            .count_o       (conv_count[g]),
            .count_valid_o (conv_cvld[g])
        );
    end

    always_comb begin
        out_d     = out_q;
        out_d.vld = accept;
        if (accept) begin
            out_d.bits = now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign stream_valid = out_q.vld;
    assign bit_a        = out_q.bits.a;
    assign bit_b        = out_q.bits.b;
    assign bit_prod     = out_q.bits.prod;
    assign bit_sum      = out_q.bits.sum;
    assign bits_seen    = conv_pos[SC_CONV_PROD];
    assign prod_partial = conv_ones[SC_CONV_PROD];
    assign sum_partial  = conv_ones[SC_CONV_SUM];
    assign prod_count   = conv_count[SC_CONV_PROD];
    assign sum_count    = conv_count[SC_CONV_SUM];
    assign count_valid  = conv_cvld[SC_CONV_PROD];

    p_prod_within_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stream_valid |-> (!bit_prod || bit_sum))
        else $error("product bit set while sum bit clear");

    p_count_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count_valid |-> (prod_count <= sum_count))
        else $error("product count above sum count");

    p_windows_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_pos[SC_CONV_PROD] == conv_pos[SC_CONV_SUM]) &&
        (conv_cvld[SC_CONV_PROD] == conv_cvld[SC_CONV_SUM]))
        else $error("converters out of step");

    p_start_discards_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!stream_valid && bits_seen == '0))
        else $error("strobe accepted alongside start");

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> (!stream_valid && !count_valid))
        else $error("outputs flagged fresh without a strobe");

endmodule

// File: tb/sc_arith_unit_tb_top.sv
module sc_arith_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int KMAX = 10;
    localparam int KW   = 4;
    localparam logic [7:0] SEED_A = 8'h01;
    localparam logic [7:0] SEED_B = 8'h5A;
    localparam logic [7:0] MASK_A = 8'hB8;
    localparam logic [7:0] MASK_B = 8'hB4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            bit_valid = 1'b0;
    logic [W-1:0]    val_a = '0;
    logic [W-1:0]    val_b = '0;
    logic [KW-1:0]   win_log2 = '0;
    logic            stream_valid, bit_a, bit_b, bit_prod, bit_sum, count_valid;
    logic [KMAX-1:0] bits_seen, prod_partial, sum_partial;
    logic [KMAX:0]   prod_count, sum_count;

    int checks = 0;
    int errors = 0;
    logic [7:0] ma, mb;
    int mk, mpos, mop, mos, last_prod, last_sum;

    sc_arith_unit #(
        .W (W), .KMAX (KMAX), .KW (KW),
        .SEED_A (SEED_A), .SEED_B (SEED_B), .MASK_A (MASK_A), .MASK_B (MASK_B)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start (start), .bit_valid (bit_valid),
        .val_a (val_a), .val_b (val_b), .win_log2 (win_log2),
        .stream_valid (stream_valid), .bit_a (bit_a), .bit_b (bit_b),
        .bit_prod (bit_prod), .bit_sum (bit_sum), .bits_seen (bits_seen),
        .prod_partial (prod_partial), .sum_partial (sum_partial),
        .prod_count (prod_count), .sum_count (sum_count), .count_valid (count_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] step(input logic [7:0] s, input logic [7:0] m);
        return {s[6:0], ^(s & m)};
    endfunction

    task automatic model_reset(input int k);
        ma = SEED_A; mb = SEED_B;
        mpos = 0; mop = 0; mos = 0;
        mk = (k > KMAX) ? KMAX : k;
    endtask

    task automatic check_partials(input string req);
        check({req, " bits_seen"}, int'(bits_seen), mpos);
        check({req, " prod_partial"}, int'(prod_partial), mop);
        check({req, " sum_partial"}, int'(sum_partial), mos);
    endtask

    // Called at a negative edge; returns at a negative edge
    task automatic do_start(input int k);
        start = 1'b1;
        win_log2 = KW'(k);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        model_reset(k);
        check("R8 start stream_valid", int'(stream_valid), 0);
        check_partials("R8 start");
    endtask

    task automatic do_bit(input int va, input int vb, input int gap);
        logic ea, eb;
        val_a = W'(va);
        val_b = W'(vb);
        bit_valid = 1'b1;
        ea = (va > int'(ma));
        eb = (vb > int'(mb));
        @(posedge clk);
        @(negedge clk);
        bit_valid = 1'b0;
        check("R5 stream_valid", int'(stream_valid), 1);
        check("R3 R2 bit_a", int'(bit_a), int'(ea));
        check("R3 R2 bit_b", int'(bit_b), int'(eb));
        check("R4 bit_prod", int'(bit_prod), int'(ea & eb));
        check("R4 bit_sum", int'(bit_sum), int'(ea | eb));
        ma = step(ma, MASK_A);
        mb = step(mb, MASK_B);
        mpos++;
        mop += int'(ea & eb);
        mos += int'(ea | eb);
        if (mpos == (1 << mk)) begin
            check("R6 count_valid at end", int'(count_valid), 1);
            check("R6 prod_count", int'(prod_count), mop);
            check("R6 sum_count", int'(sum_count), mos);
            last_prod = mop; last_sum = mos;
            mpos = 0; mop = 0; mos = 0;
        end else begin
            check("R6 count_valid mid", int'(count_valid), 0);
        end
        check_partials("R7");
        repeat (gap) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int grid[9];
        grid = '{0, 32, 64, 96, 128, 160, 192, 224, 255};
        last_prod = 0; last_sum = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 stream_valid", int'(stream_valid), 0);
        check("R1 count_valid", int'(count_valid), 0);
        check("R1 prod_count", int'(prod_count), 0);
        check("R1 sum_count", int'(sum_count), 0);
        model_reset(0);
        check_partials("R1");

        // R1 single-bit windows before any start, seeds as after reset
        for (int i = 0; i < 3; i++) do_bit(200, 100, 0);

        // Sweep operand grid over 16-bit windows, mixing back-to-back and gapped strobes
        for (int i = 0; i < 9; i++) begin
            for (int j = 0; j < 9; j++) begin
                do_start(4);
                for (int n = 0; n < 16; n++) do_bit(grid[i], grid[j], (n % 3 == 0) ? 2 : 0);
            end
        end

        // R6 next window continues without reseed
        for (int n = 0; n < 16; n++) do_bit(150, 90, 0);

        // R8 start coinciding with a strobe: strobe discarded, counts held
        start = 1'b1; bit_valid = 1'b1; win_log2 = KW'(3);
        val_a = 8'd255; val_b = 8'd255;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; bit_valid = 1'b0;
        model_reset(3);
        check("R8 discarded stream_valid", int'(stream_valid), 0);
        check("R8 held prod_count", int'(prod_count), last_prod);
        check("R8 held sum_count", int'(sum_count), last_sum);
        check_partials("R8 coincident");
        for (int n = 0; n < 4; n++) do_bit(170, 60, 0);

        // R9 idle cycles hold everything
        repeat (5) @(negedge clk);
        check("R9 idle stream_valid", int'(stream_valid), 0);
        check("R9 idle count_valid", int'(count_valid), 0);
        check_partials("R9 idle");
        for (int n = 0; n < 4; n++) do_bit(170, 60, 0);

        // R6 exponent above KMAX clamps to KMAX
        do_start(15);
        for (int n = 0; n < 1024; n++) do_bit(128, 192, 0);

        // R6 exponent zero: every bit closes a window
        do_start(0);
        for (int n = 0; n < 4; n++) do_bit(255, 1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule